// File: doc/BRIEF.md
# Highway and Farm Road Crossing Signal Controller

This block sequences the lamps at a crossing where a busy highway meets a lightly used farm road. The highway shows green by default. A car sensor on the farm road asks for a turn. The controller steps through four phases in a fixed loop: highway green, highway amber, farm green and farm amber. The road that is not moving always shows red.

A private interval timer measures every phase. It starts again from zero whenever the phase changes. It reports a short limit, used for the amber phases, and a long limit, used for the green phases. Both limits are parameters counted in clock cycles.

The highway is guaranteed a minimum green time, even when a car is already waiting. A farm green ends on the first cycle that finds no car waiting, and it never runs past the long limit. The lamp outputs are decoded directly from the phase register, so they change only on a clock edge.

Top module: `xroad_signal_ctrl`

## Requirements
- R1: While rst_n is low, the outputs show highway green and farm red (hwy_grn=1, frm_red=1, all other lamps 0). These values appear without waiting for a clock edge, and the timer restarts from zero.
- R2: Highway green lasts at least LONG_CYC cycles. It moves to highway amber only on an edge where car_wait is high and at least LONG_CYC cycles of highway green have been shown. Otherwise it stays green, whether or not a car is waiting.
- R3: Highway amber lasts exactly SHORT_CYC cycles and is always followed by farm green. The phases always follow the order highway green, highway amber, farm green, farm amber, then highway green again.
- R4: Farm green moves to farm amber on the first clock edge at which car_wait is low.
- R5: Farm green lasts at most LONG_CYC cycles, even while car_wait stays high.
- R6: Farm amber lasts exactly SHORT_CYC cycles and is always followed by highway green.
- R7: In every cycle, exactly one of hwy_grn/hwy_amb/hwy_red is 1 and exactly one of frm_grn/frm_amb/frm_red is 1. Whenever the highway lamp is not red, the farm lamp is red.
- R8: The interval timer restarts on every phase change and saturates once the long limit is reached. If a car arrives after highway green has already lasted LONG_CYC cycles or more, highway amber begins on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| car_wait | input | 1 | 1 while a car is detected on the farm road |
| hwy_grn | output | 1 | Highway green lamp |
| hwy_amb | output | 1 | Highway amber lamp |
| hwy_red | output | 1 | Highway red lamp |
| frm_grn | output | 1 | Farm road green lamp |
| frm_amb | output | 1 | Farm road amber lamp |
| frm_red | output | 1 | Farm road red lamp |

## Verification
The bench raises car_wait early in highway green. A design that skips the minimum-green guard would leave green too soon. It then drops car_wait on the first cycle of farm green. A design that keeps farm green running, or that checks the sensor one cycle late, would hold green for extra cycles. It also holds the car present through a whole farm green to catch a missing long-limit cap. A short car pulse followed by a long gap checks two cases: a timer that fails to saturate, or one that is not cleared on a phase change, would either miss the immediate exit or stretch the phases. An independent monitor measures the length of every phase. A reset in the middle of farm green must return the lamps to highway green without a clock edge and must restart the timer.

// File: rtl/xr_pkg.sv
package xr_pkg;
  typedef enum logic [1:0] {
    PH_HWY_GO   = 2'd0,
    PH_HWY_WARN = 2'd1,
    PH_FRM_GO   = 2'd2,
    PH_FRM_WARN = 2'd3
  } xr_phase_e;
endpackage

// File: rtl/xr_interval_timer.sv
module xr_interval_timer #(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = (LONG_CYC > 2) ? $clog2(LONG_CYC) : 1;
  localparam logic [CW-1:0] LIM   = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] S_LIM = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          cnt_en;

  always_comb begin
    cnt_en  = restart || (cnt != LIM);
    cnt_nxt = restart ? '0 : cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt_en)
      cnt <= cnt_nxt;
  end

  assign short_done = (cnt >= S_LIM);
  assign long_done  = (cnt == LIM);

  AST_SHORT_BEFORE_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    long_done |-> short_done); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0)); // R8
  AST_LONG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (long_done && !restart) |=> long_done); // R8
endmodule

// File: rtl/xr_phase_fsm.sv
module xr_phase_fsm
  import xr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      car,
  input  logic      short_done,
  input  logic      long_done,
  output logic      restart,
  output xr_phase_e phase
);
  xr_phase_e state;
  xr_phase_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PH_HWY_GO:   if (car && long_done) nxt = PH_HWY_WARN;
      PH_HWY_WARN: if (short_done)       nxt = PH_FRM_GO;
      PH_FRM_GO:   if (!car || long_done) nxt = PH_FRM_WARN;
      PH_FRM_WARN: if (short_done)       nxt = PH_HWY_GO;
      default:                           nxt = PH_HWY_GO;
    endcase
    restart = (nxt != state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= PH_HWY_GO;
    else
      state <= nxt;
  end

  assign phase = state;

  AST_HWY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HWY_GO && !(car && long_done)) |=> (state == PH_HWY_GO)); // R2
  AST_HWY_WARN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HWY_WARN && !short_done) |=> (state == PH_HWY_WARN)); // R3
  AST_FRM_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_FRM_GO && !car) |=> (state == PH_FRM_WARN)); // R4
  AST_FRM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_FRM_GO && long_done) |=> (state == PH_FRM_WARN)); // R5
  AST_FRM_WARN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_FRM_WARN && short_done) |=> (state == PH_HWY_GO)); // R6
endmodule

// File: rtl/xr_lamp_decode.sv
module xr_lamp_decode
  import xr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  xr_phase_e phase,
  output logic      hwy_grn,
  output logic      hwy_amb,
  output logic      hwy_red,
  output logic      frm_grn,
  output logic      frm_amb,
  output logic      frm_red
);
  always_comb begin
    hwy_grn = (phase == PH_HWY_GO);
    hwy_amb = (phase == PH_HWY_WARN);
    hwy_red = (phase == PH_FRM_GO) || (phase == PH_FRM_WARN);
    frm_grn = (phase == PH_FRM_GO);
    frm_amb = (phase == PH_FRM_WARN);
    frm_red = (phase == PH_HWY_GO) || (phase == PH_HWY_WARN);
  end

  AST_HWY_ONE_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hwy_grn, hwy_amb, hwy_red}) == 1); // R7
  AST_FRM_ONE_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({frm_grn, frm_amb, frm_red}) == 1); // R7
  AST_CROSS_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !hwy_red |-> frm_red); // R7
endmodule

// File: rtl/xroad_signal_ctrl.sv
module xroad_signal_ctrl
  import xr_pkg::*;
#(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic car_wait,
  output logic hwy_grn,
  output logic hwy_amb,
  output logic hwy_red,
  output logic frm_grn,
  output logic frm_amb,
  output logic frm_red
);
  logic      restart;
  logic      short_done;
  logic      long_done;
  xr_phase_e phase;

  xr_interval_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .short_done(short_done), .long_done(long_done)
  );

  xr_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .car(car_wait),
    .short_done(short_done), .long_done(long_done),
    .restart(restart), .phase(phase)
  );

  xr_lamp_decode u_lamps (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .hwy_grn(hwy_grn), .hwy_amb(hwy_amb), .hwy_red(hwy_red),
    .frm_grn(frm_grn), .frm_amb(frm_amb), .frm_red(frm_red)
  );
endmodule

// File: tb/sim_xroad_signal_ctrl.sv
`timescale 1ns/1ps
module sim_xroad_signal_ctrl;
  localparam int S = 3;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car_wait = 1'b0;
  logic hg, hy, hr, fg, fy, fr;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xroad_signal_ctrl #(.SHORT_CYC(S), .LONG_CYC(L)) u0 (
    .clk(clk), .rst_n(rst_n), .car_wait(car_wait),
    .hwy_grn(hg), .hwy_amb(hy), .hwy_red(hr),
    .frm_grn(fg), .frm_amb(fy), .frm_red(fr)
  );

  // phase codes: 0 highway green, 1 highway amber, 2 farm green, 3 farm amber
  function automatic logic [5:0] lamps_for(input logic [1:0] ph);
    case (ph)
      2'd0: lamps_for = 6'b100_001;
      2'd1: lamps_for = 6'b010_001;
      2'd2: lamps_for = 6'b001_100;
      default: lamps_for = 6'b001_010;
    endcase
  endfunction

  task automatic chk_lamps(input logic [1:0] ph, input string req);
    logic [5:0] act;
    act = {hg, hy, hr, fg, fy, fr};
    checks++;
    if (act !== lamps_for(ph)) begin
      errors++;
      $display("FAIL %s: lamps actual=%b expected=%b", req, act, lamps_for(ph));
    end
  endtask

  typedef struct packed {
    logic       car;
    logic [5:0] cyc;
    logic [1:0] ph;
  } step_t;

  localparam int NSTEP = 19;
  localparam step_t TBL [NSTEP] = '{
    '{1'b0, 6'd20, 2'd0},   // R2 no car: highway stays green
    '{1'b1, 6'd1,  2'd1},   // R8 late car leaves at once
    '{1'b1, 6'd2,  2'd1},   // R3 amber held
    '{1'b1, 6'd1,  2'd2},   // R3 amber -> farm green
    '{1'b1, 6'd7,  2'd2},   // R5 farm green while car held
    '{1'b1, 6'd1,  2'd3},   // R5 long limit caps farm green
    '{1'b0, 6'd2,  2'd3},   // R6 amber held
    '{1'b0, 6'd1,  2'd0},   // R6 amber -> highway green
    '{1'b1, 6'd7,  2'd0},   // R2 car waiting but minimum green not met
    '{1'b1, 6'd1,  2'd1},   // R2 leave after minimum green
    '{1'b1, 6'd3,  2'd2},   // R3
    '{1'b0, 6'd1,  2'd3},   // R4 no car: early end
    '{1'b1, 6'd3,  2'd0},   // R6
    '{1'b1, 6'd1,  2'd0},   // R2 brief pulse
    '{1'b0, 6'd10, 2'd0},   // R2 pulse gone
    '{1'b1, 6'd1,  2'd1},   // R8 saturated timer
    '{1'b0, 6'd3,  2'd2},   // R3 amber ignores sensor
    '{1'b0, 6'd1,  2'd3},   // R4
    '{1'b0, 6'd3,  2'd0}    // R6
  };

  // independent phase length and order monitor
  int run = 0;
  int prev = -1;
  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      run = 0;
      prev = -1;
    end else begin
      int cur;
      checks++;
      if ((hg + hy + hr) != 1 || (fg + fy + fr) != 1 || (!hr && !fr)) begin
        errors++;
        $display("FAIL R7: lamps actual=%b expected one per road, cross red",
                 {hg, hy, hr, fg, fy, fr});
      end
      cur = hg ? 0 : hy ? 1 : fg ? 2 : 3;
      if (prev >= 0 && cur != prev) begin
        checks++;
        if (cur != (prev + 1) % 4) begin
          errors++;
          $display("FAIL R3: phase order actual=%0d expected=%0d", cur, (prev + 1) % 4);
        end
        checks++;
        if (prev == 0 && run < L) begin
          errors++;
          $display("FAIL R2: highway green actual=%0d expected>=%0d", run, L);
        end else if (prev == 2 && run > L) begin
          errors++;
          $display("FAIL R5: farm green actual=%0d expected<=%0d", run, L);
        end else if ((prev == 1 || prev == 3) && run != S) begin
          errors++;
          $display("FAIL R6: amber length actual=%0d expected=%0d (R3)", run, S);
        end
        run = 0;
      end
      run++;
      prev = cur;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_lamps(2'd0, "R1 reset");
    rst_n = 1'b1;
    chk_lamps(2'd0, "R1 after release");

    for (int i = 0; i < NSTEP; i++) begin
      car_wait = TBL[i].car;
      repeat (int'(TBL[i].cyc)) @(posedge clk);
      @(negedge clk);
      chk_lamps(TBL[i].ph, $sformatf("step %0d R2-chain", i));
    end

    // reach farm green, then reset asynchronously
    car_wait = 1'b1;
    repeat (L + S) @(posedge clk);
    @(negedge clk);
    chk_lamps(2'd2, "R3 farm green reached");
    #0.5 rst_n = 1'b0;
    #0.5 chk_lamps(2'd0, "R1 async reset");
    @(negedge clk);
    chk_lamps(2'd0, "R1 held in reset");
    rst_n = 1'b1;
    repeat (L - 1) @(posedge clk);
    @(negedge clk);
    chk_lamps(2'd0, "R8 timer restarted by reset");
    @(negedge clk);
    chk_lamps(2'd1, "R8 exit after minimum green");
    car_wait = 1'b0;
    repeat (2 * L) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule